// File: doc/BRIEF.md
# Saturating 40-bit accumulator ALU

This block is the accumulator arithmetic stage of a DSP-style datapath. It holds two 40-bit accumulators (eight guard bits above a 32-bit working range) and two condition flags. Each accepted operation reads one accumulator as the first operand. The second operand is either the other accumulator or a 32-bit value assembled from a register pair supplied on the ports. The result is written back to the chosen accumulator on the next clock edge. The register file, instruction decode and multiplier sit outside. They present the pair values, the operation code and the selects, together with a one-cycle valid strobe.

A small state machine holds the arithmetic mode. In MODE_INT both the fractional flag and the saturation flag are clear. MODE_FRAC has only the fractional flag set. MODE_SATF has both set, and there results of the add-type operations are clamped to the signed 32-bit range. A mode-set operation moves between these states. The transitions are INT/FRAC/SATF to INT when (st=0, fx=0) is requested, to FRAC when (st=0, fx=1) is requested, and to SATF when (st=1, fx=1) is requested. A request for saturation without the fractional flag (st=1, fx=0) is the FAULT transition. It keeps the current state and pulses the fault output for one cycle.

Flag-producing operations shift the old primary flag into the history flag before they write a new primary flag. Software can therefore test two successive conditions.

Top module: `acc_alu`

## Requirements
- R1: While rst is high at a clock edge, both accumulators become 0, flag0, flag1 and mode_fault become 0, and the mode becomes MODE_INT (st_mode=0, fx_mode=0). All updates are synchronous and take effect on the edge that follows an accepted operation.
- R2: An accumulator operand is sign-extended from its bit 39. A pair operand is {sign-extended pair_hi, pair_lo}, with pair_lo in bits 15:0. use_pair=1 selects the pair as the second operand; use_pair=0 selects the accumulator chosen by src_sel. Without saturation a stored result is the exact result truncated to 40 bits.
- R3: In MODE_SATF, the results of add (code 0), subtract (1), negate (2), shifted add (7), left shift (8) and the negative branch of absolute value (3) are clamped. A value above 0x7FFFFFFF is stored as 0x007FFFFFFF, and a value below -2^31 is stored as 0xFF80000000.
- R4: Code 0 writes dst+B, code 1 writes dst-B and code 2 writes -dst, each to the accumulator chosen by dst_sel (0 selects acc0).
- R5: Absolute value (code 3) of a negative operand writes its negation and sets flag0=1. A non-negative operand is written back unchanged, with flag0=0.
- R6: Only codes 3, 4, 5 and 6 touch the flags, and each of them copies the old flag0 into flag1 while it writes the new flag0. All other codes leave both flags unchanged.
- R7: Compare (code 6) sets flag0=1 exactly when dst is signed less than B, and changes no accumulator.
- R8: Max (code 4) and min (code 5) store B into dst and set flag0=1 only when B is strictly greater (max) or strictly smaller (min) than dst. Otherwise dst is kept and flag0=0.
- R9: Shifted add (code 7) writes dst plus the src_sel accumulator arithmetically shifted right by 16. It ignores use_pair.
- R10: Shifts use the count in shamt, where a count of 0 means 16. Code 8 shifts dst left, code 9 shifts it right arithmetically, and code 10 shifts the raw 40-bit pattern right logically (zero fill). Codes 9 and 10 are never clamped.
- R11: Mode set (code 11) uses mode_st_req and mode_fx_req. When st=1 and fx=0 are requested, the mode does not change and mode_fault is 1 for the following cycle. Any other request enters the matching mode, and mode_fault is 0 after every cycle that was not such a request.
- R12: A cycle with op_valid=0, or with op_code 12 to 15, changes neither accumulator nor either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 4 | Operation code (0 to 11 defined) |
| dst_sel | input | 1 | Destination / first-operand accumulator |
| src_sel | input | 1 | Second accumulator operand |
| use_pair | input | 1 | Second operand taken from the register pair |
| pair_hi | input | 16 | Even register of the pair (upper half) |
| pair_lo | input | 16 | Odd register of the pair (lower half) |
| shamt | input | 4 | Shift count, 0 means 16 |
| mode_st_req | input | 1 | Requested saturation flag for mode set |
| mode_fx_req | input | 1 | Requested fractional flag for mode set |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| flag0 | output | 1 | Primary condition flag |
| flag1 | output | 1 | Previous value of flag0 |
| st_mode | output | 1 | Saturation currently enabled |
| fx_mode | output | 1 | Fractional mode currently enabled |
| mode_fault | output | 1 | Illegal mode request seen last cycle |

## Verification
The assertions assume that reset is held high from the first edge. They also assume that every input is stable around the rising edge and is a known 0 or 1, so each $past and $stable compares defined values. The stimulus keeps to this. It changes inputs only on the falling edge and never leaves an input undriven. The random phase draws op codes over the full 4-bit range, so the unused codes and the illegal mode request are exercised inside these limits.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_NEG  = 4'd2,
        OP_ABS  = 4'd3,
        OP_MAX  = 4'd4,
        OP_MIN  = 4'd5,
        OP_CMP  = 4'd6,
        OP_SADD = 4'd7,
        OP_SLLI = 4'd8,
        OP_SRAI = 4'd9,
        OP_SRLI = 4'd10,
        OP_MODE = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        MODE_INT  = 2'd0,
        MODE_FRAC = 2'd1,
        MODE_SATF = 2'd2
    } mode_e;

endpackage

// File: rtl/acc_alu_operand.sv
module acc_alu_operand #(
    parameter int ACC_W = 40,
    parameter int REG_W = 16,
    parameter int WIDE  = 58
) (
    input  logic [ACC_W-1:0]       acc_dst,
    input  logic [ACC_W-1:0]       acc_src,
    input  logic [REG_W-1:0]       pair_hi,
    input  logic [REG_W-1:0]       pair_lo,
    input  logic                   use_pair,
    output logic signed [WIDE-1:0] opa,
    output logic signed [WIDE-1:0] opb,
    output logic signed [WIDE-1:0] opsrc
);
    localparam int PAD_ACC  = WIDE - ACC_W;
    localparam int PAD_PAIR = WIDE - 2 * REG_W;

    logic signed [WIDE-1:0] pair_w;

    assign opa    = {{PAD_ACC{acc_dst[ACC_W-1]}}, acc_dst};
    assign opsrc  = {{PAD_ACC{acc_src[ACC_W-1]}}, acc_src};
    assign pair_w = {{PAD_PAIR{pair_hi[REG_W-1]}}, pair_hi, pair_lo};
    assign opb    = use_pair ? pair_w : opsrc;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int REG_W = 16,
    parameter int SAT_W = 32,
    parameter int WIDE  = 58,
    parameter int SHC_W = 4
) (
    input  logic [3:0]             op,
    input  logic signed [WIDE-1:0] opa,
    input  logic signed [WIDE-1:0] opb,
    input  logic signed [WIDE-1:0] opsrc,
    input  logic [ACC_W-1:0]       acc_raw,
    input  logic [SHC_W-1:0]       shamt,
    input  logic                   sat_on,
    output logic                   acc_we,
    output logic [ACC_W-1:0]       acc_val,
    output logic                   flag_we,
    output logic                   flag_val
);
    localparam logic signed [WIDE-1:0] HI_LIM =
        {{(WIDE-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [WIDE-1:0] LO_LIM = ~HI_LIM;

    logic [SHC_W:0]         shn;
    logic signed [WIDE-1:0] sum_w, dif_w, neg_w, sadd_w, sll_w, sra_w;
    logic [WIDE-1:0]        srl_w;

    function automatic logic [ACC_W-1:0] clamp(input logic signed [WIDE-1:0] v,
                                               input logic en);
        if (en && (v > HI_LIM))      return HI_LIM[ACC_W-1:0];
        else if (en && (v < LO_LIM)) return LO_LIM[ACC_W-1:0];
        else                         return v[ACC_W-1:0];
    endfunction

    assign shn    = (shamt == '0) ? (SHC_W+1)'(REG_W) : {1'b0, shamt};
    assign sum_w  = opa + opb;
    assign dif_w  = opa - opb;
    assign neg_w  = -opa;
    assign sadd_w = opa + (opsrc >>> REG_W);
    assign sll_w  = opa <<< shn;
    assign sra_w  = opa >>> shn;
    assign srl_w  = {{(WIDE-ACC_W){1'b0}}, acc_raw} >> shn;

    always_comb begin
        acc_we   = 1'b0;
        acc_val  = acc_raw;
        flag_we  = 1'b0;
        flag_val = 1'b0;
        unique case (op)
            OP_ADD:  begin acc_we = 1'b1; acc_val = clamp(sum_w, sat_on);  end
            OP_SUB:  begin acc_we = 1'b1; acc_val = clamp(dif_w, sat_on);  end
            OP_NEG:  begin acc_we = 1'b1; acc_val = clamp(neg_w, sat_on);  end
            OP_SADD: begin acc_we = 1'b1; acc_val = clamp(sadd_w, sat_on); end
            OP_SLLI: begin acc_we = 1'b1; acc_val = clamp(sll_w, sat_on);  end
            OP_SRAI: begin acc_we = 1'b1; acc_val = sra_w[ACC_W-1:0];      end
            OP_SRLI: begin acc_we = 1'b1; acc_val = srl_w[ACC_W-1:0];      end
            OP_ABS: begin
                acc_we  = 1'b1;
                flag_we = 1'b1;
                if (opa < 0) begin
                    acc_val  = clamp(neg_w, sat_on);
                    flag_val = 1'b1;
                end
            end
            OP_MAX: begin
                flag_we = 1'b1;
                if (opb > opa) begin
                    acc_we   = 1'b1;
                    acc_val  = opb[ACC_W-1:0];
                    flag_val = 1'b1;
                end
            end
            OP_MIN: begin
                flag_we = 1'b1;
                if (opb < opa) begin
                    acc_we   = 1'b1;
                    acc_val  = opb[ACC_W-1:0];
                    flag_val = 1'b1;
                end
            end
            OP_CMP: begin
                flag_we  = 1'b1;
                flag_val = (opa < opb);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu_mode.sv
module acc_alu_mode
    import acc_alu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic st_req,
    input  logic fx_req,
    output logic st_mode,
    output logic fx_mode,
    output logic fault
);
    mode_e state_q, state_d;
    logic  fault_d;

    always_comb begin
        state_d = state_q;
        fault_d = 1'b0;
        if (req) begin
            unique case ({st_req, fx_req})
                2'b00: state_d = MODE_INT;
                2'b01: state_d = MODE_FRAC;
                2'b11: state_d = MODE_SATF;
                2'b10: fault_d = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_INT;
            fault   <= 1'b0;
        end else begin
            state_q <= state_d;
            fault   <= fault_d;
        end
    end

    always_comb begin
        st_mode = 1'b0;
        fx_mode = 1'b0;
        unique case (state_q)
            MODE_INT:  ;
            MODE_FRAC: fx_mode = 1'b1;
            MODE_SATF: begin st_mode = 1'b1; fx_mode = 1'b1; end
            default:   ;
        endcase
    end

    // R11: an illegal request holds the mode and raises the fault
    p_fault_holds_mode_r11: assert property (@(posedge clk) disable iff (rst)
        (req && st_req && !fx_req) |=> (fault && $stable(st_mode) && $stable(fx_mode)));

    p_fault_only_after_bad_r11: assert property (@(posedge clk) disable iff (rst)
        !(req && st_req && !fx_req) |=> !fault);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int REG_W = 16,
    parameter int SAT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic             dst_sel,
    input  logic             src_sel,
    input  logic             use_pair,
    input  logic [REG_W-1:0] pair_hi,
    input  logic [REG_W-1:0] pair_lo,
    input  logic [$clog2(REG_W)-1:0] shamt,
    input  logic             mode_st_req,
    input  logic             mode_fx_req,
    output logic [ACC_W-1:0] acc0,
    output logic [ACC_W-1:0] acc1,
    output logic             flag0,
    output logic             flag1,
    output logic             st_mode,
    output logic             fx_mode,
    output logic             mode_fault
);
    localparam int SHC_W = $clog2(REG_W);
    localparam int WIDE  = ACC_W + REG_W + 2;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (SAT_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    logic [ACC_W-1:0]       acc_q [2];
    logic                   f0_q, f1_q;
    logic signed [WIDE-1:0] opa, opb, opsrc;
    logic                   acc_we, flag_we, flag_val;
    logic [ACC_W-1:0]       acc_val;
    logic                   mode_req;

    acc_alu_operand #(.ACC_W(ACC_W), .REG_W(REG_W), .WIDE(WIDE)) u_operand (
        .acc_dst (acc_q[dst_sel]),
        .acc_src (acc_q[src_sel]),
        .pair_hi (pair_hi),
        .pair_lo (pair_lo),
        .use_pair(use_pair),
        .opa     (opa),
        .opb     (opb),
        .opsrc   (opsrc)
    );

    acc_alu_core #(.ACC_W(ACC_W), .REG_W(REG_W), .SAT_W(SAT_W),
                   .WIDE(WIDE), .SHC_W(SHC_W)) u_core (
        .op      (op_code),
        .opa     (opa),
        .opb     (opb),
        .opsrc   (opsrc),
        .acc_raw (acc_q[dst_sel]),
        .shamt   (shamt),
        .sat_on  (st_mode),
        .acc_we  (acc_we),
        .acc_val (acc_val),
        .flag_we (flag_we),
        .flag_val(flag_val)
    );

    assign mode_req = op_valid && (op_code == OP_MODE);

    acc_alu_mode u_mode (
        .clk    (clk),
        .rst    (rst),
        .req    (mode_req),
        .st_req (mode_st_req),
        .fx_req (mode_fx_req),
        .st_mode(st_mode),
        .fx_mode(fx_mode),
        .fault  (mode_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q[0] <= '0;
            acc_q[1] <= '0;
            f0_q     <= 1'b0;
            f1_q     <= 1'b0;
        end else if (op_valid) begin
            if (acc_we) acc_q[dst_sel] <= acc_val;
            if (flag_we) begin
                f1_q <= f0_q;
                f0_q <= flag_val;
            end
        end
    end

    assign acc0  = acc_q[0];
    assign acc1  = acc_q[1];
    assign flag0 = f0_q;
    assign flag1 = f1_q;

    // R12: idle cycles and unused codes leave state alone
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || (op_code > OP_MODE)) |=>
        ($stable(acc_q[0]) && $stable(acc_q[1]) && $stable(f0_q) && $stable(f1_q)));

    // R6: flag history shifts on flag-producing operations
    p_flag_history_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code inside {OP_ABS, OP_MAX, OP_MIN, OP_CMP})) |=>
        (f1_q == $past(f0_q)));

    // R3: saturated results stay inside the signed 32-bit range
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && st_mode &&
         (op_code inside {OP_ADD, OP_SUB, OP_NEG, OP_SADD, OP_SLLI})) |=>
        (($signed($past(dst_sel) ? acc_q[1] : acc_q[0]) <= SAT_HI) &&
         ($signed($past(dst_sel) ? acc_q[1] : acc_q[0]) >= SAT_LO)));

    // R8: a losing max/min keeps the destination
    p_keep_on_loss_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code inside {OP_MAX, OP_MIN})) |=>
        (f0_q || ($past(dst_sel) ? (acc_q[1] == $past(acc_q[1]))
                                 : (acc_q[0] == $past(acc_q[0])))));

    // R7: compare never writes an accumulator
    p_cmp_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_CMP)) |=> ($stable(acc_q[0]) && $stable(acc_q[1])));
endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
    localparam int  CLK_PERIOD = 10;
    localparam longint MASK40  = 64'h00FF_FFFF_FFFF;
    localparam longint MAX32   = 64'sh7FFF_FFFF;
    localparam longint MIN32   = -64'sh8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        dst_sel = 1'b0, src_sel = 1'b0, use_pair = 1'b0;
    logic [15:0] pair_hi = 16'd0, pair_lo = 16'd0;
    logic [3:0]  shamt = 4'd0;
    logic        mode_st_req = 1'b0, mode_fx_req = 1'b0;
    logic [39:0] acc0, acc1;
    logic        flag0, flag1, st_mode, fx_mode, mode_fault;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    longint m_acc [2];
    bit m_f0, m_f1, m_st, m_fx, m_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu i_acc_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .dst_sel(dst_sel), .src_sel(src_sel), .use_pair(use_pair),
        .pair_hi(pair_hi), .pair_lo(pair_lo), .shamt(shamt),
        .mode_st_req(mode_st_req), .mode_fx_req(mode_fx_req),
        .acc0(acc0), .acc1(acc1), .flag0(flag0), .flag1(flag1),
        .st_mode(st_mode), .fx_mode(fx_mode), .mode_fault(mode_fault)
    );

    function automatic longint sx40(input longint v);
        longint t = v & MASK40;
        if (t[39]) t = t - 64'sh100_0000_0000;
        return t;
    endfunction

    function automatic longint sat(input longint v, input bit en);
        if (en && v > MAX32) return MAX32;
        if (en && v < MIN32) return MIN32 & MASK40;
        return v & MASK40;
    endfunction

    function automatic string tag_of(input logic v, input logic [3:0] op);
        if (!v || op > 4'd11) return "R12";
        case (op)
            4'd0, 4'd1, 4'd2: return "R4";
            4'd3:             return "R5";
            4'd4, 4'd5:       return "R8";
            4'd6:             return "R7";
            4'd7:             return "R9";
            4'd11:            return "R11";
            default:          return "R10";
        endcase
    endfunction

    task automatic model(input logic v, input logic [3:0] op, input logic d, input logic s,
                         input logic up, input logic [15:0] hi, input logic [15:0] lo,
                         input logic [3:0] sh, input logic stq, input logic fxq);
        longint a, b, src, r;
        int n;
        a   = sx40(m_acc[d]);
        src = sx40(m_acc[s]);
        b   = up ? longint'(signed'({hi, lo})) : src;
        n   = (sh == 0) ? 16 : int'(sh);
        m_fault = 1'b0;
        if (v) begin
            case (op)
                4'd0: m_acc[d] = sat(a + b, m_st);
                4'd1: m_acc[d] = sat(a - b, m_st);
                4'd2: m_acc[d] = sat(-a, m_st);
                4'd3: begin
                    m_f1 = m_f0;
                    if (a < 0) begin m_acc[d] = sat(-a, m_st); m_f0 = 1'b1; end
                    else m_f0 = 1'b0;
                end
                4'd4, 4'd5: begin
                    m_f1 = m_f0;
                    if ((op == 4'd4) ? (b > a) : (b < a)) begin
                        m_acc[d] = b & MASK40; m_f0 = 1'b1;
                    end else m_f0 = 1'b0;
                end
                4'd6: begin m_f1 = m_f0; m_f0 = (a < b); end
                4'd7: m_acc[d] = sat(a + (src >>> 16), m_st);
                4'd8: m_acc[d] = sat(a <<< n, m_st);
                4'd9: m_acc[d] = (a >>> n) & MASK40;
                4'd10: begin r = m_acc[d] & MASK40; m_acc[d] = r >> n; end
                4'd11: begin
                    if (stq && !fxq) m_fault = 1'b1;
                    else begin m_st = stq; m_fx = fxq; end
                end
                default: ;
            endcase
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (acc0 !== 40'(m_acc[0]) || acc1 !== 40'(m_acc[1]) || flag0 !== m_f0 ||
            flag1 !== m_f1 || st_mode !== m_st || fx_mode !== m_fx ||
            mode_fault !== m_fault) begin
            errors++;
            $display("FAIL %s: actual acc0=%h acc1=%h f0=%b f1=%b st=%b fx=%b flt=%b expected acc0=%h acc1=%h f0=%b f1=%b st=%b fx=%b flt=%b",
                     tag, acc0, acc1, flag0, flag1, st_mode, fx_mode, mode_fault,
                     40'(m_acc[0]), 40'(m_acc[1]), m_f0, m_f1, m_st, m_fx, m_fault);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [3:0] op,
                        input logic d, input logic s, input logic up,
                        input logic [15:0] hi, input logic [15:0] lo,
                        input logic [3:0] sh, input logic stq, input logic fxq);
        op_valid = v; op_code = op; dst_sel = d; src_sel = s; use_pair = up;
        pair_hi = hi; pair_lo = lo; shamt = sh; mode_st_req = stq; mode_fx_req = fxq;
        model(v, op, d, s, up, hi, lo, sh, stq, fxq);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_acc[0] = 0; m_acc[1] = 0;
        m_f0 = 0; m_f1 = 0; m_st = 0; m_fx = 0; m_fault = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        // pair formation and plain add/sub
        step("R2", 1, 4'd0, 0, 0, 1, 16'h1234, 16'h5678, 0, 0, 0);
        step("R2", 1, 4'd0, 1, 0, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0);
        step("R4", 1, 4'd1, 1, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        // shifts, count 0 meaning 16
        step("R10", 1, 4'd8, 0, 0, 0, 16'h0, 16'h0, 4'd0, 0, 0);
        step("R2", 1, 4'd8, 0, 0, 0, 16'h0, 16'h0, 4'd8, 0, 0);
        step("R10", 1, 4'd9, 0, 0, 0, 16'h0, 16'h0, 4'd4, 0, 0);
        step("R10", 1, 4'd10, 1, 0, 0, 16'h0, 16'h0, 4'd0, 0, 0);
        step("R10", 1, 4'd9, 1, 0, 0, 16'h0, 16'h0, 4'd3, 0, 0);
        // compare, max, min, abs with flag history
        step("R7", 1, 4'd6, 1, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R6", 1, 4'd6, 0, 1, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R8", 1, 4'd4, 1, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R8", 1, 4'd4, 1, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R8", 1, 4'd5, 0, 0, 1, 16'h8000, 16'h0000, 0, 0, 0);
        step("R8", 1, 4'd5, 0, 0, 1, 16'h7FFF, 16'hFFFF, 0, 0, 0);
        step("R5", 1, 4'd3, 0, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R5", 1, 4'd3, 0, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R4", 1, 4'd2, 1, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R9", 1, 4'd7, 0, 1, 1, 16'h1111, 16'h2222, 0, 0, 0);
        // mode changes and illegal request
        step("R11", 1, 4'd11, 0, 0, 0, 16'h0, 16'h0, 0, 1, 0);
        step("R11", 1, 4'd11, 0, 0, 0, 16'h0, 16'h0, 0, 0, 1);
        step("R11", 1, 4'd11, 0, 0, 0, 16'h0, 16'h0, 0, 1, 1);
        step("R11", 1, 4'd11, 0, 0, 0, 16'h0, 16'h0, 0, 1, 0);
        // saturation
        step("R3", 1, 4'd0, 0, 0, 1, 16'h7FFF, 16'hFFFF, 0, 1, 1);
        step("R3", 1, 4'd0, 0, 0, 1, 16'h7FFF, 16'hFFFF, 0, 0, 0);
        step("R3", 1, 4'd1, 1, 0, 1, 16'h7FFF, 16'hFFFF, 0, 0, 0);
        step("R3", 1, 4'd1, 1, 0, 1, 16'h7FFF, 16'hFFFF, 0, 0, 0);
        step("R3", 1, 4'd2, 1, 0, 0, 16'h0, 16'h0, 0, 0, 0);
        step("R3", 1, 4'd8, 0, 0, 0, 16'h0, 16'h0, 4'd4, 0, 0);
        step("R3", 1, 4'd3, 1, 0, 1, 16'h0, 16'h0, 0, 0, 0);
        // ignored cycles
        step("R12", 0, 4'd0, 0, 0, 1, 16'h1234, 16'h0001, 0, 0, 0);
        step("R12", 1, 4'd13, 1, 0, 1, 16'h1234, 16'h0001, 0, 0, 0);
        step("R12", 1, 4'd15, 0, 1, 0, 16'h0, 16'h0, 0, 0, 0);
        // random mix over all codes
        for (int i = 0; i < 600; i++) begin
            logic [3:0] op;
            logic v;
            op = 4'($urandom_range(0, 15));
            v  = ($urandom_range(0, 7) != 0);
            step(tag_of(v, op), v, op, 1'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule